// File: doc/BRIEF.md
# Oversampling Serial Receiver with Early Rearm

This block receives asynchronous serial frames. Each frame is one start bit, eight data bits sent least significant bit first, and a stop level. The serial line is resynchronised into the clock domain. It is then examined only on cycles where an external strobe marks one sample tick, and sixteen ticks make one bit period. A falling edge seen while idle opens a candidate start bit. That candidate is confirmed or rejected at its midpoint. The data bits are then sampled at their midpoints and shifted in.

The receiver checks a single stop bit and makes its decision on the ninth tick of the stop period. It does not wait out the rest of that period: as soon as a high stop sample is taken, it delivers the byte and goes back to hunting for the next falling edge. A sender that runs slightly faster than the receiver can therefore send frames with no gap between them, and the timing error does not pile up from one frame to the next. A low stop sample gives a framing-error pulse in place of data. The receiver then stays parked until the line has returned high.

Top module: `serial_rx_x16`

## Requirements
- R1: The serial input passes through a two-flop synchronizer, and state advances only on cycles where `sample_tick` is high. A frame begins when, while idle, a tick sees the line low after a tick that saw it high.
- R2: If the synchronized line is high at the 8th tick of a candidate start bit, the candidate is dropped. No data pulse and no error pulse result, and the receiver returns to idle.
- R3: Eight data bits are taken at the 8th tick of their bit periods, the first one received going to bit 0 of `rx_data`. The delivered byte equals the byte sent.
- R4: Exactly one stop bit is tested, at the 9th tick of the stop period. When it is high, `rx_valid` pulses for one clock and `rx_data` carries the new byte in that same cycle.
- R5: When the stop sample is low, `rx_frame_err` pulses for one clock, `rx_valid` stays low, and `rx_data` keeps its previous value.
- R6: After a framing error no new frame can start until a tick has seen the line high. A line held low for many bit times gives exactly one error pulse.
- R7: After a valid stop sample the receiver hunts for a start edge on the very next tick. Back-to-back frames from a sender whose bit period is 31/32 of the nominal one are all received correctly.
- R8: Frames separated by idle time, and frames sent with two stop bits, are received correctly.
- R9: `rx_valid` and `rx_frame_err` are never high together, and neither stays high for two clocks in a row.
- R10: A synchronous reset, including one in the middle of a frame, drops any partial frame, returns the receiver to idle and clears `rx_data`, `rx_valid` and `rx_frame_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last byte received with a valid stop bit |
| rx_valid | output | 1 | One-cycle pulse when a byte is delivered |
| rx_frame_err | output | 1 | One-cycle pulse when the stop sample is low |

## Verification
The main hazard is back-to-back traffic from a fast sender. A receiver that sits through the whole stop period catches each following start edge about a third of a bit late, and within a few frames it begins to sample the wrong bits. The bench therefore sends a long gapless run at a bit period of 31/32 nominal and compares every byte. A full sweep of all 256 byte values at the nominal rate exposes any bit-order or shift-count error. Short low glitches must leave no trace; a design that skips the midpoint recheck would deliver junk bytes or framing errors. A long break after a bad stop bit must raise exactly one error pulse, and a reset part-way through a frame must leave nothing behind.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_STOP  = 3'd3,
        ST_HOLD  = 3'd4
    } srx_state_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   STAGES      = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RESET_LEVEL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int DW      = 8,
    parameter int MID     = 8,
    parameter int STOP_AT = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          line,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          ferr
);

    localparam int CW = $clog2(OSR + 1);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] MID_C  = CW'(MID);
    localparam logic [CW-1:0] END_C  = CW'(OSR);
    localparam logic [CW-1:0] STOP_C = CW'(STOP_AT);
    localparam logic [BW-1:0] LAST_C = BW'(DW - 1);

    typedef struct packed {
        srx_state_e    st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bit_idx;
        logic [DW-1:0] shreg;
        logic          prev;
        logic [DW-1:0] data;
        logic          valid;
        logic          ferr;
    } frame_t;

    frame_t        d;
    frame_t        q;
    logic [CW-1:0] nxt;
    logic [DW:0]   shifted;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.ferr  = 1'b0;
        nxt     = q.cnt + 1'b1;
        shifted = {line, q.shreg} >> 1;
        if (tick) begin
            d.prev = line;
            case (q.st)
                ST_IDLE: begin
                    if (q.prev && !line) begin
                        d.st  = ST_START;
                        d.cnt = CW'(1);
                    end
                end
                ST_START: begin
                    d.cnt = nxt;
                    if (nxt == MID_C && line) begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                    end else if (nxt == END_C) begin
                        d.st      = ST_DATA;
                        d.cnt     = '0;
                        d.bit_idx = '0;
                    end
                end
                ST_DATA: begin
                    d.cnt = nxt;
                    if (nxt == MID_C) begin
                        d.shreg = shifted[DW-1:0];
                    end
                    if (nxt == END_C) begin
                        d.cnt = '0;
                        if (q.bit_idx == LAST_C) begin
                            d.st = ST_STOP;
                        end else begin
                            d.bit_idx = q.bit_idx + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    d.cnt = nxt;
                    if (nxt == STOP_C) begin
                        d.cnt = '0;
                        if (line) begin
                            d.valid = 1'b1;
                            d.data  = q.shreg;
                            d.st    = ST_IDLE;
                        end else begin
                            d.ferr = 1'b1;
                            d.st   = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (line) begin
                        d.st = ST_IDLE;
                    end
                end
                default: begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st      <= ST_IDLE;
            q.cnt     <= '0;
            q.bit_idx <= '0;
            q.shreg   <= '0;
            q.prev    <= 1'b0;
            q.data    <= '0;
            q.valid   <= 1'b0;
            q.ferr    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data  = q.data;
    assign valid = q.valid;
    assign ferr  = q.ferr;

    // R9: the two pulses exclude each other and last one clock
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(valid && ferr));
    p_valid_short_r9: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    p_ferr_short_r9: assert property (@(posedge clk) disable iff (rst)
        ferr |=> !ferr);
    // R1: outputs move only in response to a sample tick
    p_tick_gated_r1: assert property (@(posedge clk) disable iff (rst)
        (valid || ferr) |-> $past(tick));
    // R4: delivery needs a high stop sample
    p_stop_high_r4: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(line));
    // R5: an error needs a low stop sample, and data holds otherwise
    p_stop_low_r5: assert property (@(posedge clk) disable iff (rst)
        ferr |-> !$past(line));
    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(data) |-> valid);
    // R6: parked receiver only leaves on a high line sample
    p_hold_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_HOLD && !(tick && line)) |=> q.st == ST_HOLD);

endmodule

// File: rtl/serial_rx_x16.sv
module serial_rx_x16 #(
    parameter int OSR         = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MID         = OSR / 2,
    parameter int STOP_AT     = OSR / 2 + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_tick,
    input  logic          rx_serial,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_frame_err
);

    logic line_s;

    srx_sync #(
        .STAGES      (SYNC_STAGES),
        .RESET_LEVEL (1'b1)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_serial),
        .dout (line_s)
    );

    srx_frame #(
        .OSR     (OSR),
        .DW      (DW),
        .MID     (MID),
        .STOP_AT (STOP_AT)
    ) u_frame (
        .clk   (clk),
        .rst   (rst),
        .tick  (sample_tick),
        .line  (line_s),
        .data  (rx_data),
        .valid (rx_valid),
        .ferr  (rx_frame_err)
    );

endmodule

// File: tb/serial_rx_x16_tb.sv
module serial_rx_x16_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int NOM_BIT    = 32;
    localparam int FAST_BIT   = 31;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic       rx_serial = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;

    int n_checks = 0;
    int n_fail = 0;
    int n_log = 0;
    int n_err = 0;
    int tdiv = 0;
    bit done = 0;
    logic       valid_prev = 1'b0;
    logic       err_prev = 1'b0;
    logic [7:0] rx_log [0:1023];

    serial_rx_x16 u_dut (
        .clk          (clk),
        .rst          (rst),
        .sample_tick  (sample_tick),
        .rx_serial    (rx_serial),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        sample_tick = (tdiv == 0);
        tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        if (!rst) begin
            if (rx_valid) begin
                rx_log[n_log[9:0]] = rx_data;
                n_log++;
            end
            if (rx_frame_err) n_err++;
            if (rx_valid && rx_frame_err) chk(0, "R9 both pulses high", 1, 0);
            if (rx_valid && valid_prev) chk(0, "R9 valid wider than one clock", 2, 1);
            if (rx_frame_err && err_prev) chk(0, "R9 error wider than one clock", 2, 1);
        end
        valid_prev = rx_valid;
        err_prev = rx_frame_err;
    end

    task automatic drive_bit(input logic v, input int n);
        rx_serial = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        drive_bit(1'b1, n);
    endtask

    task automatic send_frame(input logic [7:0] b, input int bitclk,
                              input int nstop, input logic stopval);
        drive_bit(1'b0, bitclk);
        for (int i = 0; i < 8; i++) drive_bit(b[i], bitclk);
        for (int s = 0; s < nstop; s++) drive_bit(stopval, bitclk);
    endtask

    task automatic expect_bytes(input int base, input int count, input string tag,
                                input logic [7:0] first, input int step);
        logic [7:0] e;
        chk(n_log - base == count, {tag, " frame count"}, n_log - base, count);
        e = first;
        for (int i = 0; i < count; i++) begin
            chk(rx_log[10'(base + i)] == e, {tag, " byte value"}, rx_log[10'(base + i)], e);
            e = e + 8'(step);
        end
    endtask

    initial begin
        int base;
        int errs;
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(rx_data == 8'h00, "R10 data after reset", rx_data, 0);
        chk(rx_valid == 1'b0, "R10 valid after reset", rx_valid, 0);
        chk(rx_frame_err == 1'b0, "R10 error after reset", rx_frame_err, 0);
        rst = 1'b0;
        idle(100);

        // R3 R4 R7: all byte values, nominal rate, no gaps
        base = n_log;
        for (int v = 0; v < 256; v++) send_frame(8'(v), NOM_BIT, 1, 1'b1);
        idle(100);
        expect_bytes(base, 256, "R3 nominal sweep", 8'h00, 1);
        chk(n_err == 0, "R4 no framing errors in sweep", n_err, 0);

        // R7: gapless frames from a sender 1/32 faster
        base = n_log;
        for (int k = 0; k < 64; k++) send_frame(8'(k * 37 + 11), FAST_BIT, 1, 1'b1);
        idle(100);
        expect_bytes(base, 64, "R7 fast sender", 8'd11, 37);
        chk(n_err == 0, "R7 no framing errors fast", n_err, 0);

        // R8: idle gaps and two stop bits
        base = n_log;
        send_frame(8'hA5, NOM_BIT, 1, 1'b1); idle(50);
        send_frame(8'hA6, NOM_BIT, 1, 1'b1); idle(200);
        send_frame(8'hA7, NOM_BIT, 1, 1'b1); idle(7);
        for (int k = 0; k < 4; k++) send_frame(8'(8'hA8 + k), NOM_BIT, 2, 1'b1);
        idle(100);
        expect_bytes(base, 7, "R8 gaps and two stops", 8'hA5, 1);

        // R2: short low glitches are rejected
        base = n_log;
        errs = n_err;
        drive_bit(1'b0, 4);  idle(200);
        drive_bit(1'b0, 10); idle(200);
        chk(n_log == base, "R2 glitch gives no byte", n_log - base, 0);
        chk(n_err == errs, "R2 glitch gives no error", n_err - errs, 0);
        chk(rx_data == 8'hAB, "R2 data unchanged by glitch", rx_data, 8'hAB);

        // R5 R6: bad stop followed by a long break
        send_frame(8'h5A, NOM_BIT, 1, 1'b0);
        drive_bit(1'b0, 40 * NOM_BIT);
        idle(200);
        chk(n_err - errs == 1, "R6 single error for long break", n_err - errs, 1);
        chk(n_log == base, "R5 no byte on bad stop", n_log - base, 0);
        chk(rx_data == 8'hAB, "R5 data kept on bad stop", rx_data, 8'hAB);
        send_frame(8'hC3, NOM_BIT, 1, 1'b1);
        idle(100);
        expect_bytes(base, 1, "R6 recovery after break", 8'hC3, 0);

        // R10: reset in the middle of a frame
        base = n_log;
        drive_bit(1'b0, NOM_BIT);
        drive_bit(1'b1, NOM_BIT);
        drive_bit(1'b0, NOM_BIT / 2);
        rst = 1'b1;
        rx_serial = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_data == 8'h00, "R10 data cleared mid-frame", rx_data, 0);
        chk(rx_valid == 1'b0 && rx_frame_err == 1'b0, "R10 pulses cleared", rx_valid, 0);
        rst = 1'b0;
        idle(400);
        chk(n_log == base, "R10 partial frame dropped", n_log - base, 0);
        send_frame(8'h81, NOM_BIT, 1, 1'b1);
        idle(100);
        expect_bytes(base, 1, "R1 frame after reset", 8'h81, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            chk(0, "R7 watchdog expired", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule